// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block is the interrupt entry path of a small 16-bit processor core. It watches several request sources: one non-maskable line, sensed on its rising edge; one maskable line, sensed on its level and gated by the interrupt-enable flag; and strobes from the execution unit for divide error, breakpoint, overflow trap, software interrupt and end of instruction (which, with the trap flag set, requests single-step). When idle, it picks one source and works out an 8-bit type code.

For most sources the type code is fixed. For the maskable line, the block runs two active-low acknowledge pulses, and the external controller drives the code during the second. The block then reads the four-byte pointer for that type from the low 1 KiB of memory through a byte-wide read port. It reports the new instruction pointer, the new code segment and the 20-bit start address (segment times 16 plus offset) together with a one-cycle done strobe. In that same cycle it signals the core to clear the interrupt-enable and trap flags.

Internal strobes are single-cycle and are presented only while `busy_o` is low. The core stalls until `done_o`.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `inta_n_o` is 1 and `mem_rd_o`, `done_o` and `busy_o` are 0.
- R2: A divide-error strobe yields type 0 and a breakpoint strobe yields type 3. An overflow-trap strobe yields type 4 only while `ovf_i` is 1. With `ovf_i` at 0 it has no effect: `busy_o` stays 0 and no done strobe follows.
- R3: A software-interrupt strobe yields the type given on `swi_type_i`, for any value from 0 to 255.
- R4: A rising edge on `nmi_i` yields type 2 and is never masked. The edge stays pending until it is serviced, so a one-cycle pulse that arrives while a sequence is running is still serviced afterwards.
- R5: A high `intr_i` is ignored while `if_i` is 0: no acknowledge pulse, no memory read, and `busy_o` stays 0. It is honoured once `if_i` is 1.
- R6: A maskable request gets exactly two `inta_n_o` low pulses of one cycle each, separated by one high cycle. The type is sampled from `ack_type_i` at the end of the second pulse, and no memory read is issued while `inta_n_o` is low.
- R7: `insn_done_i` while `tf_i` is 1 raises a single-step request of type 1, which stays pending until serviced.
- R8: When several sources are pending, service order is: internal exception or software interrupt first, then NMI, then maskable, then single-step. Among simultaneous internal strobes the order is divide, breakpoint, overflow trap, software.
- R9: For type n, four reads are issued in consecutive cycles at byte addresses 4n, 4n+1, 4n+2, 4n+3. Read data is taken one cycle after its address.
- R10: `new_ip_o` is byte(4n) + 256·byte(4n+1), `new_cs_o` is byte(4n+2) + 256·byte(4n+3), and `isr_addr_o` is 16·`new_cs_o` + `new_ip_o` modulo 2^20. All are valid while `done_o` is 1.
- R11: `done_o` lasts one cycle per sequence, with `flag_clr_o` high in the same cycle and `vec_type_o` equal to the serviced type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensed |
| intr_i | input | 1 | Maskable request, level sensed |
| if_i | input | 1 | Interrupt-enable flag from the core |
| tf_i | input | 1 | Trap flag from the core |
| insn_done_i | input | 1 | Instruction boundary strobe |
| exc_div_i | input | 1 | Divide error strobe |
| exc_brk_i | input | 1 | Breakpoint instruction strobe |
| exc_into_i | input | 1 | Overflow-trap instruction strobe |
| ovf_i | input | 1 | Overflow flag from the core |
| swi_i | input | 1 | Software interrupt strobe |
| swi_type_i | input | 8 | Type operand of the software interrupt |
| inta_n_o | output | 1 | Active-low interrupt acknowledge |
| ack_type_i | input | 8 | Type code from the external controller |
| mem_rd_o | output | 1 | Vector table read request |
| mem_addr_o | output | 20 | Vector table byte address |
| mem_rdata_i | input | 8 | Read data, one cycle after the request |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle completion strobe |
| vec_type_o | output | 8 | Type code serviced |
| new_ip_o | output | 16 | New instruction pointer |
| new_cs_o | output | 16 | New code segment |
| isr_addr_o | output | 20 | Physical start address of the handler |
| flag_clr_o | output | 1 | Clear interrupt-enable and trap flags |

## Verification
The bench fires a divide error, an NMI pulse, a held maskable request and a single-step request in the same cycle. It expects types 0, 2, controller code and 1, in that order. A design with the wrong priority would return them out of order, and one that dropped an unserviced edge would skip type 2. A maskable request held while interrupts are disabled must start nothing. A design that ignored the enable flag would pulse acknowledge and fetch early. The acknowledge responder drives a decoy code during the first pulse, so a design that sampled in the wrong pulse fetches the wrong vector. An overflow trap with the flag clear must stay silent, and an NMI pulse during a running fetch must still be serviced afterwards.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

   typedef enum logic [2:0] {
      SRC_NONE,
      SRC_EXC,
      SRC_NMI,
      SRC_INTR,
      SRC_STEP
   } irq_src_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ACK1,
      ST_GAP,
      ST_ACK2,
      ST_READ,
      ST_DONE
   } seq_st_e;

   localparam int unsigned CODE_DIV  = 0;
   localparam int unsigned CODE_STEP = 1;
   localparam int unsigned CODE_NMI  = 2;
   localparam int unsigned CODE_BRK  = 3;
   localparam int unsigned CODE_OVF  = 4;

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_entry_pkg::*;
#(
   parameter int unsigned TYPE_W   = 8,
   parameter int unsigned NMI_SYNC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idle_i,
   input  logic              nmi_i,
   input  logic              intr_i,
   input  logic              if_i,
   input  logic              tf_i,
   input  logic              insn_done_i,
   input  logic              exc_div_i,
   input  logic              exc_brk_i,
   input  logic              exc_into_i,
   input  logic              ovf_i,
   input  logic              swi_i,
   input  logic [TYPE_W-1:0] swi_type_i,
   output logic              grant_o,
   output irq_src_e          src_o,
   output logic [TYPE_W-1:0] type_o
);

   logic nmi_s, nmi_q, nmi_rise, nmi_pend_r, step_pend_r;
   logic nmi_pend, step_pend, exc_any;

   // Optional synchroniser ahead of the edge detector
   if (NMI_SYNC == 0) begin : g_nosync
      assign nmi_s = nmi_i;
   end else begin : g_sync
      logic [NMI_SYNC-1:0] sh;
      always_ff @(posedge clk) begin
         if (!rst_n) sh[0] <= 1'b0;
         else        sh[0] <= nmi_i;
      end
      for (genvar k = 1; k < NMI_SYNC; k++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) sh[k] <= 1'b0;
            else        sh[k] <= sh[k-1];
         end
      end
      assign nmi_s = sh[NMI_SYNC-1];
   end

   assign nmi_rise  = nmi_s & ~nmi_q;
   assign nmi_pend  = nmi_pend_r | nmi_rise;
   assign step_pend = step_pend_r | (tf_i & insn_done_i);
   assign exc_any   = exc_div_i | exc_brk_i | (exc_into_i & ovf_i) | swi_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nmi_q       <= 1'b0;
         nmi_pend_r  <= 1'b0;
         step_pend_r <= 1'b0;
      end else begin
         nmi_q       <= nmi_s;
         nmi_pend_r  <= nmi_pend  & ~(grant_o && src_o == SRC_NMI);
         step_pend_r <= step_pend & ~(grant_o && src_o == SRC_STEP);
      end
   end

   always_comb begin
      grant_o = 1'b0;
      src_o   = SRC_NONE;
      type_o  = '0;
      if (idle_i) begin
         if (exc_any) begin
            grant_o = 1'b1;
            src_o   = SRC_EXC;
            if (exc_div_i)                type_o = TYPE_W'(CODE_DIV);
            else if (exc_brk_i)           type_o = TYPE_W'(CODE_BRK);
            else if (exc_into_i && ovf_i) type_o = TYPE_W'(CODE_OVF);
            else                          type_o = swi_type_i;
         end else if (nmi_pend) begin
            grant_o = 1'b1;
            src_o   = SRC_NMI;
            type_o  = TYPE_W'(CODE_NMI);
         end else if (intr_i && if_i) begin
            grant_o = 1'b1;
            src_o   = SRC_INTR;
         end else if (step_pend) begin
            grant_o = 1'b1;
            src_o   = SRC_STEP;
            type_o  = TYPE_W'(CODE_STEP);
         end
      end
   end

   // R5
   intr_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o && src_o == SRC_INTR) |-> (if_i && intr_i));

   // R4
   nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_pend && !(grant_o && src_o == SRC_NMI)) |=> nmi_pend_r);

endmodule

// File: rtl/irq_vec_fetch.sv
module irq_vec_fetch
   import irq_entry_pkg::*;
#(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned TYPE_W = 8,
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              grant_i,
   input  irq_src_e          src_i,
   input  logic [TYPE_W-1:0] type_i,
   input  logic [TYPE_W-1:0] ack_type_i,
   input  logic [7:0]        mem_rdata_i,
   output logic              idle_o,
   output logic              inta_n_o,
   output logic              mem_rd_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              done_o,
   output logic [TYPE_W-1:0] vec_type_o,
   output logic [WORD_W-1:0] new_ip_o,
   output logic [WORD_W-1:0] new_cs_o
);

   localparam int unsigned VEC_BYTES = (2 * WORD_W) / 8;
   localparam int unsigned OFF_W     = $clog2(VEC_BYTES);
   localparam int unsigned IDX_W     = $clog2(VEC_BYTES + 1);

   seq_st_e                 state;
   logic [TYPE_W-1:0]       type_r;
   logic [IDX_W-1:0]        idx;
   logic [2*WORD_W-1:0]     vec_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         type_r <= '0;
         idx    <= '0;
         vec_r  <= '0;
      end else begin
         case (state)
            ST_IDLE: if (grant_i) begin
               type_r <= type_i;
               idx    <= '0;
               state  <= (src_i == SRC_INTR) ? ST_ACK1 : ST_READ;
            end
            ST_ACK1: state <= ST_GAP;
            ST_GAP:  state <= ST_ACK2;
            ST_ACK2: begin
               type_r <= ack_type_i;
               state  <= ST_READ;
            end
            ST_READ: begin
               for (int b = 0; b < VEC_BYTES; b++)
                  if (idx == IDX_W'(b + 1)) vec_r[8*b +: 8] <= mem_rdata_i;
               idx <= idx + 1'b1;
               if (idx == IDX_W'(VEC_BYTES)) state <= ST_DONE;
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign idle_o     = (state == ST_IDLE);
   assign inta_n_o   = !(state == ST_ACK1 || state == ST_ACK2);
   assign mem_rd_o   = (state == ST_READ) && (idx < IDX_W'(VEC_BYTES));
   assign mem_addr_o = ADDR_W'({type_r, idx[OFF_W-1:0]});
   assign done_o     = (state == ST_DONE);
   assign vec_type_o = type_r;
   assign new_ip_o   = vec_r[WORD_W-1:0];
   assign new_cs_o   = vec_r[2*WORD_W-1:WORD_W];

   // R6
   ack_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !inta_n_o |-> !mem_rd_o);

   // R6
   ack_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(inta_n_o) |=> (!inta_n_o || $stable(inta_n_o)));

   // R9
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_o && $past(mem_rd_o)) |-> (mem_addr_o == $past(mem_addr_o) + 1'b1));

   // R11
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_entry_pkg::*;
#(
   parameter int unsigned ADDR_W    = 20,
   parameter int unsigned TYPE_W    = 8,
   parameter int unsigned WORD_W    = 16,
   parameter int unsigned SEG_SHIFT = 4,
   parameter int unsigned NMI_SYNC  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nmi_i,
   input  logic              intr_i,
   input  logic              if_i,
   input  logic              tf_i,
   input  logic              insn_done_i,
   input  logic              exc_div_i,
   input  logic              exc_brk_i,
   input  logic              exc_into_i,
   input  logic              ovf_i,
   input  logic              swi_i,
   input  logic [TYPE_W-1:0] swi_type_i,
   output logic              inta_n_o,
   input  logic [TYPE_W-1:0] ack_type_i,
   output logic              mem_rd_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic [7:0]        mem_rdata_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [TYPE_W-1:0] vec_type_o,
   output logic [WORD_W-1:0] new_ip_o,
   output logic [WORD_W-1:0] new_cs_o,
   output logic [ADDR_W-1:0] isr_addr_o,
   output logic              flag_clr_o
);

   if (ADDR_W != WORD_W + SEG_SHIFT) begin : g_bad_addr
      $error("ADDR_W must equal WORD_W + SEG_SHIFT");
   end
   if (TYPE_W + 2 > ADDR_W) begin : g_bad_type
      $error("vector table does not fit in the address space");
   end
   if (WORD_W % 8 != 0) begin : g_bad_word
      $error("WORD_W must be a whole number of bytes");
   end

   logic              idle, grant;
   irq_src_e          src;
   logic [TYPE_W-1:0] gtype;

   irq_arbiter #(.TYPE_W(TYPE_W), .NMI_SYNC(NMI_SYNC)) u_arb (
      .clk         (clk),
      .rst_n       (rst_n),
      .idle_i      (idle),
      .nmi_i       (nmi_i),
      .intr_i      (intr_i),
      .if_i        (if_i),
      .tf_i        (tf_i),
      .insn_done_i (insn_done_i),
      .exc_div_i   (exc_div_i),
      .exc_brk_i   (exc_brk_i),
      .exc_into_i  (exc_into_i),
      .ovf_i       (ovf_i),
      .swi_i       (swi_i),
      .swi_type_i  (swi_type_i),
      .grant_o     (grant),
      .src_o       (src),
      .type_o      (gtype)
   );

   irq_vec_fetch #(.ADDR_W(ADDR_W), .TYPE_W(TYPE_W), .WORD_W(WORD_W)) u_fetch (
      .clk         (clk),
      .rst_n       (rst_n),
      .grant_i     (grant),
      .src_i       (src),
      .type_i      (gtype),
      .ack_type_i  (ack_type_i),
      .mem_rdata_i (mem_rdata_i),
      .idle_o      (idle),
      .inta_n_o    (inta_n_o),
      .mem_rd_o    (mem_rd_o),
      .mem_addr_o  (mem_addr_o),
      .done_o      (done_o),
      .vec_type_o  (vec_type_o),
      .new_ip_o    (new_ip_o),
      .new_cs_o    (new_cs_o)
   );

   assign busy_o     = !idle;
   assign flag_clr_o = done_o;
   assign isr_addr_o = {new_cs_o, {SEG_SHIFT{1'b0}}} + ADDR_W'(new_ip_o);

endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       nmi_i = 0, intr_i = 0, if_i = 0, tf_i = 0, insn_done_i = 0;
   logic       exc_div_i = 0, exc_brk_i = 0, exc_into_i = 0, ovf_i = 0, swi_i = 0;
   logic [7:0] swi_type_i = 0;
   logic       inta_n_o;
   logic [7:0] ack_type_i = 8'h55;
   logic       mem_rd_o;
   logic [19:0] mem_addr_o;
   logic [7:0] mem_rdata_i = 0;
   logic       busy_o, done_o, flag_clr_o;
   logic [7:0] vec_type_o;
   logic [15:0] new_ip_o, new_cs_o;
   logic [19:0] isr_addr_o;

   int checks = 0;
   int errors = 0;
   int ack_pulses = 0;
   logic [7:0] dev_type = 8'h00;
   logic [7:0]  exp_q[$];
   logic [19:0] addr_q[$];
   bit finished = 0;

   always #2 clk = ~clk;

   irq_entry_seq u_irq_entry_seq (
      .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .intr_i(intr_i), .if_i(if_i),
      .tf_i(tf_i), .insn_done_i(insn_done_i), .exc_div_i(exc_div_i),
      .exc_brk_i(exc_brk_i), .exc_into_i(exc_into_i), .ovf_i(ovf_i),
      .swi_i(swi_i), .swi_type_i(swi_type_i), .inta_n_o(inta_n_o),
      .ack_type_i(ack_type_i), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
      .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o),
      .vec_type_o(vec_type_o), .new_ip_o(new_ip_o), .new_cs_o(new_cs_o),
      .isr_addr_o(isr_addr_o), .flag_clr_o(flag_clr_o)
   );

   function automatic logic [7:0] vbyte(input logic [19:0] a);
      logic [19:0] t;
      t = a * 20'd37 + (a >> 3) + 20'd11;
      return t[7:0];
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // vector memory with one-cycle read latency
   always @(posedge clk) if (mem_rd_o) mem_rdata_i <= vbyte(mem_addr_o);

   // external acknowledge responder: decoy code on pulse one, real code on pulse two
   always @(negedge inta_n_o) begin
      ack_pulses++;
      if (ack_pulses % 2 == 0) ack_type_i = dev_type;
   end
   always @(posedge inta_n_o) begin
      if (ack_pulses % 2 == 0) begin
         intr_i     = 1'b0;
         ack_type_i = 8'h55;
      end
   end

   // monitor: read addresses and completed sequences
   always @(negedge clk) begin
      if (rst_n && mem_rd_o) begin
         chk(inta_n_o, "R6 read during ack", {31'd0, inta_n_o}, 32'd1);
         addr_q.push_back(mem_addr_o);
      end
      if (rst_n && done_o) begin
         if (exp_q.size() == 0) begin
            chk(0, "R11 unexpected done", {24'd0, vec_type_o}, 32'hffff_ffff);
         end else begin
            logic [7:0]  n;
            logic [19:0] base;
            logic [15:0] eip, ecs;
            logic [19:0] eisr;
            n    = exp_q.pop_front();
            base = {10'd0, n, 2'b00};
            eip  = {vbyte(base + 20'd1), vbyte(base)};
            ecs  = {vbyte(base + 20'd3), vbyte(base + 20'd2)};
            eisr = {ecs, 4'h0} + {4'h0, eip};
            chk(vec_type_o == n, "R8 type order", {24'd0, vec_type_o}, {24'd0, n});
            chk(addr_q.size() == 4, "R9 read count", addr_q.size(), 4);
            for (int k = 0; k < 4; k++)
               if (k < addr_q.size())
                  chk(addr_q[k] == base + 20'(k), "R9 read address",
                      {12'd0, addr_q[k]}, {12'd0, base + 20'(k)});
            chk(new_ip_o == eip, "R10 ip", {16'd0, new_ip_o}, {16'd0, eip});
            chk(new_cs_o == ecs, "R10 cs", {16'd0, new_cs_o}, {16'd0, ecs});
            chk(isr_addr_o == eisr, "R10 isr address", {12'd0, isr_addr_o}, {12'd0, eisr});
            chk(flag_clr_o, "R11 flag clear", {31'd0, flag_clr_o}, 32'd1);
         end
         addr_q.delete();
      end
   end

   // R11 done lasts one cycle
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         @(negedge clk);
         chk(!done_o, "R11 done width", {31'd0, done_o}, 32'd0);
      end
   end

   task automatic wait_quiet();
      int guard = 0;
      @(negedge clk);
      while ((exp_q.size() != 0 || busy_o) && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, "R8 outstanding sequences", exp_q.size(), 0);
   endtask

   task automatic strobe(input int which, input logic [7:0] n);
      @(negedge clk);
      case (which)
         0: exc_div_i  = 1;
         1: exc_brk_i  = 1;
         2: exc_into_i = 1;
         3: begin swi_i = 1; swi_type_i = n; end
         default: begin tf_i = 1; insn_done_i = 1; end
      endcase
      @(negedge clk);
      exc_div_i = 0; exc_brk_i = 0; exc_into_i = 0; swi_i = 0; insn_done_i = 0;
      tf_i = 0;
   endtask

   task automatic quiet_window(input string req, input int cycles);
      int p0 = ack_pulses;
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         chk(!busy_o && !mem_rd_o && !done_o, req, {29'd0, busy_o, mem_rd_o, done_o}, 0);
      end
      chk(ack_pulses == p0, req, ack_pulses, p0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(inta_n_o && !mem_rd_o && !done_o && !busy_o, "R1 reset state",
          {28'd0, inta_n_o, mem_rd_o, done_o, busy_o}, 32'h8);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 fixed exception codes
      exp_q.push_back(8'd0); strobe(0, 0); wait_quiet();
      exp_q.push_back(8'd3); strobe(1, 0); wait_quiet();
      ovf_i = 1;
      exp_q.push_back(8'd4); strobe(2, 0); wait_quiet();
      ovf_i = 0;
      strobe(2, 0);
      quiet_window("R2 overflow trap with flag clear", 15);

      // R3 software interrupts across the range
      exp_q.push_back(8'hC7); strobe(3, 8'hC7); wait_quiet();
      exp_q.push_back(8'hFF); strobe(3, 8'hFF); wait_quiet();
      exp_q.push_back(8'h20); strobe(3, 8'h20); wait_quiet();

      // R4 NMI pulse
      exp_q.push_back(8'd2);
      @(negedge clk); nmi_i = 1; @(negedge clk); nmi_i = 0;
      wait_quiet();

      // R5 R6 maskable request honoured
      begin
         int p0 = ack_pulses;
         dev_type = 8'h41; if_i = 1;
         exp_q.push_back(8'h41);
         @(negedge clk); intr_i = 1;
         wait_quiet();
         chk(ack_pulses - p0 == 2, "R6 ack pulse count", ack_pulses - p0, 2);
      end

      // R5 masked then enabled
      if_i = 0; dev_type = 8'h80;
      @(negedge clk); intr_i = 1;
      quiet_window("R5 masked request", 20);
      exp_q.push_back(8'h80);
      if_i = 1;
      wait_quiet();
      if_i = 0;

      // R7 single step
      exp_q.push_back(8'd1); strobe(4, 0); wait_quiet();

      // R8 all sources at once
      if_i = 1; dev_type = 8'h33;
      exp_q.push_back(8'd0); exp_q.push_back(8'd2);
      exp_q.push_back(8'h33); exp_q.push_back(8'd1);
      @(negedge clk);
      intr_i = 1; nmi_i = 1; exc_div_i = 1; tf_i = 1; insn_done_i = 1;
      @(negedge clk);
      nmi_i = 0; exc_div_i = 0; tf_i = 0; insn_done_i = 0;
      wait_quiet();
      if_i = 0;

      // R8 simultaneous internal strobes: breakpoint beats software
      exp_q.push_back(8'd3);
      @(negedge clk); exc_brk_i = 1; swi_i = 1; swi_type_i = 8'h99;
      @(negedge clk); exc_brk_i = 0; swi_i = 0;
      wait_quiet();

      // R4 NMI pulse during a running fetch
      exp_q.push_back(8'hA5); exp_q.push_back(8'd2);
      strobe(3, 8'hA5);
      repeat (2) @(negedge clk);
      nmi_i = 1; @(negedge clk); nmi_i = 0;
      wait_quiet();

      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule